// File: doc/BRIEF.md
# Pixel Sample Sequencer with Byte-Wide Result Output

This block paces the sampling of one pixel on a three-channel front end. A pulse on the pixel-start input, seen at a rising clock edge, makes it issue a signal-sample strobe in the following cycle. After a programmable gap of one to four clocks it issues a reference-sample strobe. When correlated sampling is switched off, the reference strobe is flagged as taking the internal reference rather than the input. The pixel period is simply the spacing between pixel-start pulses.

A clamp is requested by raising the clamp input together with pixel start. The clamp then stays enabled for the whole pixel that the pulse opens. A level-select output, taken from the polarity setting, tells the analog side which reference rail to clamp to. The 14-bit conversion result of each pixel is captured with pixel start and is put out on an 8-bit bus over two consecutive cycles, high byte first, with a phase flag beside it.

A new pixel start that arrives while a reference strobe is still waiting raises a one-cycle timing error and cancels that strobe.

Top module: `pixel_sample_seq`

## Requirements
- R1: While reset is held, and in the first cycle after reset, every output is 0.
- R2: A pixel-start seen high at a clock edge drives the signal strobe high for exactly the one cycle that follows that edge.
- R3: The reference strobe goes high for one cycle, `dly+1` cycles after the signal strobe. Here `dly` is the 2-bit delay setting (0 to 3) sampled with pixel start.
- R4: With correlated sampling disabled at pixel start, the internal-reference flag is high in the same cycle as the reference strobe. With it enabled, the flag stays 0.
- R5: Clamp-enable takes the clamp-request value seen at the pixel-start edge and holds it until the next pixel start. The request is ignored at every other edge.
- R6: The clamp level output takes the polarity setting at pixel start (1 = upper reference, 0 = lower) and holds it for the pixel.
- R7: In the cycle after pixel start, the bus carries result bits 13..6 and the phase flag is 1.
- R8: In the next cycle, the bus carries result bits 5..0 on bus bits 7..2, with bus bits 1..0 at 0, and the phase flag is 0. The bus then holds that value until the next pixel start.
- R9: A pixel start at an edge where a reference strobe is pending but not firing gives a one-cycle timing error pulse. The pending strobe is cancelled, and the new pixel runs normally.
- R10: Changes of the delay, sampling-mode, polarity and clamp inputs between pixel starts have no effect on the pixel in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_start_i | input | 1 | Pixel-start pulse |
| clamp_req_i | input | 1 | Clamp request, valid with pixel start |
| ref_dly_i | input | 2 | Reference delay minus one, in clocks |
| cds_en_i | input | 1 | 1 = correlated sampling of the input reference |
| polarity_i | input | 1 | Clamp rail select: 1 upper, 0 lower |
| conv_data_i | input | 14 | Conversion result, captured with pixel start |
| samp_sig_o | output | 1 | Signal-sample strobe |
| samp_ref_o | output | 1 | Reference-sample strobe |
| ref_int_o | output | 1 | Reference strobe uses internal reference |
| clamp_en_o | output | 1 | Clamp enabled for the current pixel |
| clamp_hi_o | output | 1 | Clamp level: 1 upper, 0 lower |
| data_o | output | 8 | Byte-wide result bus |
| byte_hi_o | output | 1 | 1 while data_o holds the high byte |
| timing_err_o | output | 1 | Pixel start arrived before the reference strobe |

## Verification
Pixels are run with every delay setting, so each possible placement of the reference strobe is seen. Each setting is also run at its shortest clean period, which separates a strobe that is late by one clock from one at the right slot. Result words with distinct bit patterns in the upper and lower parts show whether the split and the zero padding are right. Toggling the configuration inputs in the middle of a pixel shows whether they were latched. A pixel start placed inside the reference window checks the error pulse and the cancellation: any leftover strobe from the old pixel would appear in a slot where none is expected.

// File: rtl/pixel_sample_pkg.sv
// Package: shared defaults and types for the pixel sample sequencer.
// Assumes: consumers take widths as parameters and use these only as defaults.
package pixel_sample_pkg;

    parameter int unsigned PS_DATA_W = 14;  // conversion result width
    parameter int unsigned PS_BUS_W  = 8;   // output bus width
    parameter int unsigned PS_DLY_W  = 2;   // reference delay setting width

    // Settings captured for the clamp path at each pixel start.
    typedef struct packed {
        logic enable;
        logic upper;
    } clamp_cfg_t;

    // Which half of the result the bus is presenting.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } byte_phase_e;

endpackage

// File: rtl/pss_strobe_gen.sv
// Module: pss_strobe_gen
// Issues the signal-sample strobe one clock after pixel start, and the
// reference-sample strobe dly+1 clocks after that. It flags whether the
// reference comes from the internal source, and reports a pixel start that
// cuts a pending reference short.
// Assumes: pixel start is synchronous to clk. The delay and mode inputs
// only need to be valid at the pixel-start edge.
module pss_strobe_gen #(
    parameter int unsigned DLY_W = pixel_sample_pkg::PS_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             cds_en_i,
    output logic             sig_o,
    output logic             ref_o,
    output logic             ref_int_o,
    output logic             err_o
);

    logic             pend_q;
    logic [DLY_W-1:0] cnt_q;
    logic             cds_q;
    logic             fire;
    logic             sig_q;
    logic             ref_q;
    logic             ref_int_q;
    logic             err_q;

    // The pending reference fires when its countdown has reached zero.
    always_comb fire = pend_q && (cnt_q == '0);

    // Countdown state: load on pixel start, count down while pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            cds_q  <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b1;
            cnt_q  <= dly_i;
            cds_q  <= cds_en_i;
        end else if (fire) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Registered strobes and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q     <= 1'b0;
            ref_q     <= 1'b0;
            ref_int_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            sig_q     <= start_i;
            ref_q     <= fire;
            ref_int_q <= fire && !cds_q;
            err_q     <= start_i && pend_q && !fire;
        end
    end

    assign sig_o     = sig_q;
    assign ref_o     = ref_q;
    assign ref_int_o = ref_int_q;
    assign err_o     = err_q;

    AST_SIG_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> sig_o);                                    // R2
    AST_REF_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_o) |-> $past(pend_q));                       // R3
    AST_INT_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_int_o |-> ref_o);                                  // R4
    AST_ERR_CANCELS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (sig_o && !ref_o));                          // R9

endmodule

// File: rtl/pss_clamp_ctl.sv
// Module: pss_clamp_ctl
// Captures the clamp request and the rail selection at each pixel start and
// holds them for the whole pixel.
// Assumes: a clamp request is meaningful only when it coincides with pixel start.
module pss_clamp_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clamp_req_i,
    input  logic polarity_i,
    output logic clamp_en_o,
    output logic clamp_hi_o
);

    import pixel_sample_pkg::*;

    clamp_cfg_t cfg_q;

    // Latch the clamp settings for the pixel that this start opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (start_i) begin
            cfg_q.enable <= clamp_req_i;
            cfg_q.upper  <= polarity_i;
        end
    end

    assign clamp_en_o = cfg_q.enable;
    assign clamp_hi_o = cfg_q.upper;

    AST_CLAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(clamp_en_o));                     // R5
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(clamp_hi_o));                     // R6

endmodule

// File: rtl/pss_byte_mux.sv
// Module: pss_byte_mux
// Captures the conversion result at pixel start. It puts the upper BUS_W
// bits on the bus for one cycle, then the remaining low bits left-justified
// with zero fill, and holds that byte until the next pixel.
// Assumes: DATA_W > BUS_W and DATA_W <= 2*BUS_W. A pixel lasts at least two
// clocks, or the low byte is overwritten.
module pss_byte_mux #(
    parameter int unsigned DATA_W = pixel_sample_pkg::PS_DATA_W,
    parameter int unsigned BUS_W  = pixel_sample_pkg::PS_BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [BUS_W-1:0]  bus_o,
    output logic              hi_o
);

    import pixel_sample_pkg::*;

    localparam int unsigned LO_W = DATA_W - BUS_W;
    localparam int unsigned PAD  = BUS_W - LO_W;
    localparam logic [BUS_W-1:0] PAD_MASK = BUS_W'((1 << PAD) - 1);

    logic [LO_W-1:0]  lo_q;
    logic [BUS_W-1:0] bus_q;
    byte_phase_e      ph_q;

    // Byte sequencer: high byte on pixel start, low byte one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            bus_q <= '0;
            ph_q  <= PH_LOW;
        end else if (start_i) begin
            bus_q <= data_i[DATA_W-1 -: BUS_W];
            lo_q  <= data_i[LO_W-1:0];
            ph_q  <= PH_HIGH;
        end else if (ph_q == PH_HIGH) begin
            bus_q <= BUS_W'(lo_q) << PAD;
            ph_q  <= PH_LOW;
        end
    end

    assign bus_o = bus_q;
    assign hi_o  = (ph_q == PH_HIGH);

    AST_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_o && !start_i) |=> !hi_o);                         // R8
    AST_LOW_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_o) |-> ((bus_o & PAD_MASK) == '0));           // R8
    AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_o && !start_i) |=> $stable(bus_o));               // R8

endmodule

// File: rtl/pixel_sample_seq.sv
// Module: pixel_sample_seq (top)
// Per-pixel sample strobes, clamp control and byte-wide output of the
// conversion result, all paced by the master clock and the pixel-start pulse.
// Assumes: every input is synchronous to clk. Configuration inputs are
// sampled only at pixel start.
module pixel_sample_seq #(
    parameter int unsigned DATA_W = pixel_sample_pkg::PS_DATA_W,
    parameter int unsigned BUS_W  = pixel_sample_pkg::PS_BUS_W,
    parameter int unsigned DLY_W  = pixel_sample_pkg::PS_DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_start_i,
    input  logic              clamp_req_i,
    input  logic [DLY_W-1:0]  ref_dly_i,
    input  logic              cds_en_i,
    input  logic              polarity_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              samp_sig_o,
    output logic              samp_ref_o,
    output logic              ref_int_o,
    output logic              clamp_en_o,
    output logic              clamp_hi_o,
    output logic [BUS_W-1:0]  data_o,
    output logic              byte_hi_o,
    output logic              timing_err_o
);

    pss_strobe_gen #(.DLY_W(DLY_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (pix_start_i),
        .dly_i     (ref_dly_i),
        .cds_en_i  (cds_en_i),
        .sig_o     (samp_sig_o),
        .ref_o     (samp_ref_o),
        .ref_int_o (ref_int_o),
        .err_o     (timing_err_o)
    );

    pss_clamp_ctl u_clamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (pix_start_i),
        .clamp_req_i (clamp_req_i),
        .polarity_i  (polarity_i),
        .clamp_en_o  (clamp_en_o),
        .clamp_hi_o  (clamp_hi_o)
    );

    pss_byte_mux #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pix_start_i),
        .data_i  (conv_data_i),
        .bus_o   (data_o),
        .hi_o    (byte_hi_o)
    );

    AST_HIGH_WITH_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        samp_sig_o |-> byte_hi_o);                             // R7

endmodule

// File: tb/pixel_sample_seq_bench.sv
module pixel_sample_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_start_i = 1'b0;
    logic        clamp_req_i = 1'b0;
    logic [1:0]  ref_dly_i = 2'd0;
    logic        cds_en_i = 1'b0;
    logic        polarity_i = 1'b0;
    logic [13:0] conv_data_i = '0;
    logic        samp_sig_o, samp_ref_o, ref_int_o, clamp_en_o, clamp_hi_o;
    logic [7:0]  data_o;
    logic        byte_hi_o, timing_err_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pixel_sample_seq u_pixel_sample_seq (
        .clk(clk), .rst_n(rst_n), .pix_start_i(pix_start_i),
        .clamp_req_i(clamp_req_i), .ref_dly_i(ref_dly_i), .cds_en_i(cds_en_i),
        .polarity_i(polarity_i), .conv_data_i(conv_data_i),
        .samp_sig_o(samp_sig_o), .samp_ref_o(samp_ref_o), .ref_int_o(ref_int_o),
        .clamp_en_o(clamp_en_o), .clamp_hi_o(clamp_hi_o), .data_o(data_o),
        .byte_hi_o(byte_hi_o), .timing_err_o(timing_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock and sample 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One pixel of `period` clocks. Configuration inputs are scrambled after the start edge.
    task automatic run_pixel(input logic [13:0] d, input logic [1:0] dly,
                             input logic cds, input logic clmp, input logic pol,
                             input int period);
        for (int i = 0; i < period; i++) begin
            if (i == 0) begin
                pix_start_i = 1'b1; conv_data_i = d; ref_dly_i = dly;
                cds_en_i = cds; clamp_req_i = clmp; polarity_i = pol;
            end else begin
                pix_start_i = 1'b0; conv_data_i = ~d; ref_dly_i = ~dly;   // R10
                cds_en_i = ~cds; clamp_req_i = ~clmp; polarity_i = ~pol;
            end
            tick();
            check("R2 sig strobe", samp_sig_o, (i == 0));
            check("R3 ref strobe", samp_ref_o, (i == dly + 1));
            check("R4 int ref", ref_int_o, (i == dly + 1) && !cds);
            check("R5 clamp en", clamp_en_o, clmp);
            check("R6 clamp level", clamp_hi_o, pol);
            check("R7 R8 phase", byte_hi_o, (i == 0));
            check("R7 R8 bus", data_o, (i == 0) ? int'(d[13:6]) : int'({d[5:0], 2'b00}));
            check("R9 no err", timing_err_o, 0);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        pix_start_i = 1'b1; clamp_req_i = 1'b1; conv_data_i = 14'h3fff;
        tick(); tick();
        check("R1 reset sig", samp_sig_o, 0);
        check("R1 reset bus", data_o, 0);
        check("R1 reset misc", {samp_ref_o, ref_int_o, clamp_en_o, clamp_hi_o,
                                byte_hi_o, timing_err_o}, 0);
        pix_start_i = 1'b0; clamp_req_i = 1'b0;
        rst_n = 1'b1;
        tick();
        check("R1 after reset", {samp_sig_o, samp_ref_o, clamp_en_o, byte_hi_o,
                                 timing_err_o, data_o}, 0);
    endtask

    task automatic test_all_delays();
        for (int k = 0; k < 4; k++) begin
            run_pixel(14'h2a5c ^ 14'(k * 14'h111), 2'(k), k[0], k[1], ~k[0], k + 2);
            run_pixel(14'h15a3, 2'(k), 1'b1, 1'b0, 1'b1, 6);
        end
    endtask

    task automatic test_patterns();
        run_pixel(14'h3fff, 2'd1, 1'b0, 1'b1, 1'b1, 4);
        run_pixel(14'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 5);
        run_pixel(14'h2001, 2'd0, 1'b0, 1'b1, 1'b0, 3);
        run_pixel(14'h003f, 2'd3, 1'b1, 1'b1, 1'b1, 7);
    endtask

    // Start again while a delay-3 reference is pending; the old strobe must vanish.
    task automatic test_early_start();
        pix_start_i = 1'b1; ref_dly_i = 2'd3; cds_en_i = 1'b0; conv_data_i = 14'h1234;
        tick();
        pix_start_i = 1'b0;
        tick();
        pix_start_i = 1'b1; ref_dly_i = 2'd1; cds_en_i = 1'b1; conv_data_i = 14'h0abc;
        tick();
        check("R9 err pulse", timing_err_o, 1);
        check("R9 new sig", samp_sig_o, 1);
        check("R9 ref cancelled", samp_ref_o, 0);
        check("R9 new high byte", data_o, 14'h0abc >> 6);
        pix_start_i = 1'b0;
        tick();
        check("R9 err one cycle", timing_err_o, 0);
        check("R9 no ref yet", samp_ref_o, 0);
        tick();
        check("R9 new ref at slot", samp_ref_o, 1);
        check("R9 new ref cds", ref_int_o, 0);
        tick();
        check("R9 old ref gone", samp_ref_o, 0);
        tick();
        check("R9 still quiet", {samp_ref_o, timing_err_o}, 0);
    endtask

    initial begin
        test_reset();
        test_all_delays();
        test_patterns();
        test_early_start();
        run_pixel(14'h1e1e, 2'd2, 1'b0, 1'b0, 1'b1, 4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule